// File: doc/BRIEF.md
# Configurable LUT Logic Cell

A single programmable logic element: a 4-input lookup table whose result either leaves the cell directly or passes through an optional register, plus a dedicated carry element for fast arithmetic. All configuration (truth table, cascade select, output register select, clock polarity, clock-enable use, set/reset use and set-versus-reset choice) arrives as static inputs that hold steady during operation.

Cells are meant to be tiled. The LUT result leaves on a cascade output that a neighbour can take as its LUT input 2 in place of its general pin. The carry element forms the majority of logic inputs 1 and 2 and the carry input, so a chain of cells, each with its LUT set to a 3-input XOR, builds a ripple adder or a registered counter. The LUT takes the incoming carry on a general input that the fabric routes in.

Top module: `logic_cell`

## Requirements
- R1: `casc_out` equals `cfg_truth[k]`, where k = {LUT in 3, LUT in 2, LUT in 1, LUT in 0} with LUT input 3 as the most significant bit. LUT inputs 0, 1 and 3 are `lc_in[0]`, `lc_in[1]` and `lc_in[3]`.
- R2: LUT input 2 is `casc_in` when `cfg_casc_sel` = 1 and `lc_in[2]` when `cfg_casc_sel` = 0.
- R3: With `cfg_reg_out` = 0, `lc_out` follows the LUT result with no clock. With `cfg_reg_out` = 1, `lc_out` shows the register and does not change between active clock edges.
- R4: The register loads the LUT result on the rising edge of `clk` when `cfg_neg_edge` = 0 and on the falling edge when `cfg_neg_edge` = 1. It ignores the other edge.
- R5: With `cfg_use_ce` = 1, an active edge with `ce` = 0 leaves the register unchanged. With `cfg_use_ce` = 0, the register loads on every active edge whatever `ce` is.
- R6: With `cfg_use_sr` = 1 and `sr` = 1, the active edge forces the register to `cfg_sr_is_set` (1 = set, 0 = reset). This takes effect even when `ce` = 0 or the LUT result differs.
- R7: With `cfg_use_sr` = 0, `sr` has no effect on the register.
- R8: `carry_out` is the majority of `lc_in[1]`, `lc_in[2]` and `carry_in`.
- R9: An active edge with `rst_n` = 0 clears the register to 0. This takes priority over set.
- R10: Cells chained carry-out to the next cell's carry input and to its `lc_in[3]`, with the LUT set to XOR of inputs 1 to 3, add two words. With outputs registered and fed back, they count up by one per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Synchronous active-low reset of the register |
| cfg_truth | input | 16 | LUT truth table, bit k for input vector k |
| cfg_casc_sel | input | 1 | 1: LUT input 2 from `casc_in` |
| cfg_reg_out | input | 1 | 1: main output from register |
| cfg_neg_edge | input | 1 | 1: register on falling edge |
| cfg_use_ce | input | 1 | 1: honour `ce` |
| cfg_use_sr | input | 1 | 1: honour `sr` |
| cfg_sr_is_set | input | 1 | 1: `sr` sets, 0: `sr` resets |
| lc_in | input | 4 | General logic inputs |
| casc_in | input | 1 | Cascade input from neighbour |
| casc_out | output | 1 | Combinational LUT result |
| carry_in | input | 1 | Carry input |
| carry_out | output | 1 | Carry output |
| ce | input | 1 | Clock enable |
| sr | input | 1 | Set/reset request |
| lc_out | output | 1 | Main output |

## Verification
Set/reset and clock enable can land on the same active edge. The bench arranges this by holding `ce` low while raising `sr`, in both set and reset mode, and also with `ce` high and the LUT result opposite to the forced value. It judges the outcome by the registered output after that edge: the forced value must appear. In the same way, it drives `rst_n` low together with `sr` in set mode and expects 0.

// File: rtl/cell_pkg.sv
// cell_pkg: shared constants and types for the logic cell.
// Assumes a LUT of at least three inputs, so that pins 1 and 2 exist.
package cell_pkg;
    localparam int LUT_INPUTS_DEF = 4;
    localparam int CASC_PIN       = 2;  // LUT input replaceable by cascade
    localparam int CARRY_OP_A     = 1;  // carry operand taps
    localparam int CARRY_OP_B     = 2;

    // Register behaviour bundle, decoded from static configuration
    typedef struct packed {
        logic neg_edge;
        logic use_ce;
        logic use_sr;
        logic sr_is_set;
    } reg_mode_t;
endpackage

// File: rtl/cell_lut.sv
// cell_lut: lookup table built as a binary mux tree over the truth table.
// Input CASC_PIN may be swapped for the cascade input. Purely combinational.
module cell_lut #(
    parameter int N = cell_pkg::LUT_INPUTS_DEF
) (
    input  logic [(1<<N)-1:0] truth,
    input  logic [N-1:0]      pins,
    input  logic              casc_in,
    input  logic              casc_sel,
    output logic              result
);
    localparam int SIZE  = 1 << N;
    localparam int NODES = 2 * SIZE - 1;

    logic [N-1:0]     idx;
    logic [NODES-1:0] node;

    // Build the select vector, swapping in the cascade input where chosen
    always_comb begin
        idx = pins;
        idx[cell_pkg::CASC_PIN] = casc_sel ? casc_in : pins[cell_pkg::CASC_PIN];
    end

    // Leaves of the heap-ordered tree hold the truth-table bits
    for (genvar k = 0; k < SIZE; k++) begin : g_leaf
        assign node[SIZE-1+k] = truth[k];
    end

    // Each level selects on one index bit; the root uses the MSB
    for (genvar d = 0; d < N; d++) begin : g_lvl
        for (genvar j = 0; j < (1 << d); j++) begin : g_node
            assign node[(1<<d)-1+j] = idx[N-1-d] ? node[(1<<(d+1))-1+2*j+1]
                                                 : node[(1<<(d+1))-1+2*j];
        end
    end

    assign result = node[0];
endmodule

// File: rtl/cell_carry.sv
// cell_carry: majority-of-three carry element for ripple arithmetic.
// Assumes its operands are already tapped from the cell's logic inputs.
module cell_carry (
    input  logic op_a,
    input  logic op_b,
    input  logic cin,
    output logic cout
);
    // Carry is set when at least two of the three terms are set
    always_comb cout = (op_a & op_b) | (op_a & cin) | (op_b & cin);
endmodule

// File: rtl/cell_reg.sv
// cell_reg: optional output register with selectable edge, enable and
// set/reset use. Reset (sync, active low) beats set/reset, which beats enable.
// Assumes mode inputs are static while rst_n is high.
module cell_reg (
    input  logic                clk,
    input  logic                rst_n,
    input  cell_pkg::reg_mode_t mode,
    input  logic                d,
    input  logic                ce,
    input  logic                sr,
    output logic                q
);
    logic clk_act;
    logic load_en;
    logic force_en;

    // Polarity: invert the clock so falling edges become active edges
    assign clk_act = clk ^ mode.neg_edge;

    // Decode whether this edge loads data or forces the set/reset value
    always_comb begin
        force_en = mode.use_sr & sr;
        load_en  = ~mode.use_ce | ce;
    end

    // State update on the active edge
    always_ff @(posedge clk_act) begin
        if (!rst_n)        q <= 1'b0;
        else if (force_en) q <= mode.sr_is_set;
        else if (load_en)  q <= d;
    end
endmodule

// File: rtl/logic_cell.sv
// logic_cell: one programmable logic cell with LUT, optional register and
// carry element. All cfg_* inputs are static configuration.
module logic_cell #(
    parameter int LUT_INPUTS = cell_pkg::LUT_INPUTS_DEF,
    localparam int TT_BITS   = 1 << LUT_INPUTS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TT_BITS-1:0]    cfg_truth,
    input  logic                  cfg_casc_sel,
    input  logic                  cfg_reg_out,
    input  logic                  cfg_neg_edge,
    input  logic                  cfg_use_ce,
    input  logic                  cfg_use_sr,
    input  logic                  cfg_sr_is_set,
    input  logic [LUT_INPUTS-1:0] lc_in,
    input  logic                  casc_in,
    output logic                  casc_out,
    input  logic                  carry_in,
    output logic                  carry_out,
    input  logic                  ce,
    input  logic                  sr,
    output logic                  lc_out
);
    cell_pkg::reg_mode_t mode;
    logic lut_q;
    logic reg_q;

    // Bundle register configuration
    always_comb begin
        mode.neg_edge  = cfg_neg_edge;
        mode.use_ce    = cfg_use_ce;
        mode.use_sr    = cfg_use_sr;
        mode.sr_is_set = cfg_sr_is_set;
    end

    cell_lut #(.N(LUT_INPUTS)) u_lut (
        .truth    (cfg_truth),
        .pins     (lc_in),
        .casc_in  (casc_in),
        .casc_sel (cfg_casc_sel),
        .result   (lut_q)
    );

    cell_carry u_carry (
        .op_a (lc_in[cell_pkg::CARRY_OP_A]),
        .op_b (lc_in[cell_pkg::CARRY_OP_B]),
        .cin  (carry_in),
        .cout (carry_out)
    );

    cell_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .d     (lut_q),
        .ce    (ce),
        .sr    (sr),
        .q     (reg_q)
    );

    // Output selection: cascade always raw, main output registered or raw
    assign casc_out = lut_q;
    assign lc_out   = cfg_reg_out ? reg_q : lut_q;
endmodule

// File: rtl/logic_cell_checker.sv
// logic_cell_checker: temporal properties of the cell, bound to logic_cell.
// Assumes configuration changes only while rst_n is low.
module logic_cell_checker #(
    parameter int LUT_INPUTS = cell_pkg::LUT_INPUTS_DEF,
    localparam int TT_BITS   = 1 << LUT_INPUTS
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [TT_BITS-1:0]    cfg_truth,
    input logic                  cfg_casc_sel,
    input logic                  cfg_reg_out,
    input logic                  cfg_neg_edge,
    input logic                  cfg_use_ce,
    input logic                  cfg_use_sr,
    input logic                  cfg_sr_is_set,
    input logic [LUT_INPUTS-1:0] lc_in,
    input logic                  casc_in,
    input logic                  casc_out,
    input logic                  carry_in,
    input logic                  carry_out,
    input logic                  ce,
    input logic                  sr,
    input logic                  lc_out
);
    logic [LUT_INPUTS-1:0] ref_idx;

    // Reference index with the cascade substitution
    always_comb begin
        ref_idx = lc_in;
        if (cfg_casc_sel) ref_idx[cell_pkg::CASC_PIN] = casc_in;
    end

    a_r1_lut_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        casc_out == cfg_truth[ref_idx]);

    a_r3_raw_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_reg_out |-> lc_out == casc_out);

    a_r8_carry_majority: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out == ((lc_in[1] & lc_in[2]) | (lc_in[1] & carry_in) | (lc_in[2] & carry_in)));

    a_r5_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_neg_edge && cfg_reg_out && cfg_use_ce && !ce && !(cfg_use_sr && sr))
        |=> $stable(lc_out));

    a_r6_sr_force_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_neg_edge && cfg_reg_out && cfg_use_sr && sr) |=> lc_out == cfg_sr_is_set);

    a_r6_sr_force_neg: assert property (@(negedge clk) disable iff (!rst_n)
        (cfg_neg_edge && cfg_reg_out && cfg_use_sr && sr) |=> lc_out == cfg_sr_is_set);
endmodule

bind logic_cell logic_cell_checker #(.LUT_INPUTS(LUT_INPUTS)) u_chk (.*);

// File: tb/tb_logic_cell.sv
// tb_logic_cell: directed tests of one cell plus adder and counter chains.
module tb_logic_cell;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] cfg_truth = '0;
    logic cfg_casc_sel = 0, cfg_reg_out = 0, cfg_neg_edge = 0;
    logic cfg_use_ce = 0, cfg_use_sr = 0, cfg_sr_is_set = 0;
    logic [3:0] lc_in = '0;
    logic casc_in = 0, carry_in = 0, ce = 0, sr = 0;
    logic casc_out, carry_out, lc_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;  // 125 MHz

    logic_cell dut (
        .clk(clk), .rst_n(rst_n), .cfg_truth(cfg_truth),
        .cfg_casc_sel(cfg_casc_sel), .cfg_reg_out(cfg_reg_out),
        .cfg_neg_edge(cfg_neg_edge), .cfg_use_ce(cfg_use_ce),
        .cfg_use_sr(cfg_use_sr), .cfg_sr_is_set(cfg_sr_is_set),
        .lc_in(lc_in), .casc_in(casc_in), .casc_out(casc_out),
        .carry_in(carry_in), .carry_out(carry_out), .ce(ce), .sr(sr),
        .lc_out(lc_out)
    );

    // XOR of LUT inputs 1..3, computed per index
    function automatic logic [15:0] xor3_tt();
        logic [15:0] t;
        for (int k = 0; k < 16; k++) t[k] = k[1] ^ k[2] ^ k[3];
        return t;
    endfunction

    // Adder chain: operands on inputs 1 and 2, carry on input 3
    logic [W-1:0] add_a = '0, add_b = '0;
    logic         add_cin = 0;
    logic [W:0]   add_c;
    logic [W-1:0] add_s;
    // Counter chain: registered output fed back on input 1
    logic [W:0]   cnt_c;
    logic [W-1:0] cnt_q;
    logic         cnt_rst_n = 1'b0;

    assign add_c[0] = add_cin;
    assign cnt_c[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_chain
        logic unused_a, unused_b;
        logic_cell u_add (
            .clk(clk), .rst_n(rst_n), .cfg_truth(xor3_tt()),
            .cfg_casc_sel(1'b0), .cfg_reg_out(1'b0), .cfg_neg_edge(1'b0),
            .cfg_use_ce(1'b0), .cfg_use_sr(1'b0), .cfg_sr_is_set(1'b0),
            .lc_in({add_c[i], add_b[i], add_a[i], 1'b0}), .casc_in(1'b0),
            .casc_out(unused_a), .carry_in(add_c[i]), .carry_out(add_c[i+1]),
            .ce(1'b1), .sr(1'b0), .lc_out(add_s[i])
        );
        logic_cell u_cnt (
            .clk(clk), .rst_n(cnt_rst_n), .cfg_truth(xor3_tt()),
            .cfg_casc_sel(1'b0), .cfg_reg_out(1'b1), .cfg_neg_edge(1'b0),
            .cfg_use_ce(1'b0), .cfg_use_sr(1'b0), .cfg_sr_is_set(1'b0),
            .lc_in({cnt_c[i], 1'b0, cnt_q[i], 1'b0}), .casc_in(1'b0),
            .casc_out(unused_b), .carry_in(cnt_c[i]), .carry_out(cnt_c[i+1]),
            .ce(1'b1), .sr(1'b0), .lc_out(cnt_q[i])
        );
    end

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Wait for the active edge of the current polarity, then settle
    task automatic step();
        if (cfg_neg_edge) @(negedge clk); else @(posedge clk);
        #1;
    endtask

    // Wait for the edge the register must ignore, then settle
    task automatic idle_edge();
        if (cfg_neg_edge) @(posedge clk); else @(negedge clk);
        #1;
    endtask

    // Apply configuration under reset, then release
    task automatic configure(input logic [15:0] tt, input logic rego, input logic neg,
                             input logic uce, input logic usr, input logic sset);
        rst_n = 1'b0;
        #1;
        cfg_truth = tt; cfg_reg_out = rego; cfg_neg_edge = neg;
        cfg_use_ce = uce; cfg_use_sr = usr; cfg_sr_is_set = sset;
        cfg_casc_sel = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        configure(16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check(lc_out, 0, "R9 reset state");
    endtask

    task automatic t_lut();
        logic [15:0] pats [2] = '{16'h6D2B, 16'h8001};
        configure(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        foreach (pats[p]) begin
            cfg_truth = pats[p];
            for (int k = 0; k < 16; k++) begin
                lc_in = k[3:0];
                #1;
                check(casc_out, pats[p][k], "R1 lut lookup");
                check(lc_out, pats[p][k], "R3 raw output");
            end
        end
    endtask

    task automatic t_cascade();
        configure(16'hF0F0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);  // result = LUT in 2
        cfg_casc_sel = 1'b1; lc_in = 4'b0000; casc_in = 1'b1; #1;
        check(casc_out, 1, "R2 cascade selected high");
        lc_in = 4'b0100; casc_in = 1'b0; #1;
        check(casc_out, 0, "R2 pin ignored when cascade selected");
        cfg_casc_sel = 1'b0; #1;
        check(casc_out, 1, "R2 pin selected");
        casc_in = 1'b1; lc_in = 4'b0000; #1;
        check(casc_out, 0, "R2 cascade ignored");
        cfg_casc_sel = 1'b0; casc_in = 1'b0;
    endtask

    task automatic t_edges(input logic neg);
        configure(16'hAAAA, 1'b1, neg, 1'b0, 1'b0, 1'b0);  // result = LUT in 0
        lc_in = 4'b0001;
        #1;
        check(lc_out, 0, "R3 registered output waits for edge");
        idle_edge();
        check(lc_out, 0, "R4 inactive edge ignored");
        step();
        check(lc_out, 1, "R4 active edge loads");
        lc_in = 4'b0000;
        idle_edge();
        check(lc_out, 1, "R4 inactive edge ignored on fall");
        step();
        check(lc_out, 0, "R4 active edge loads zero");
    endtask

    task automatic t_enable();
        configure(16'hAAAA, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        ce = 1'b1; lc_in = 4'b0001; step();
        check(lc_out, 1, "R5 load with ce");
        ce = 1'b0; lc_in = 4'b0000; step();
        check(lc_out, 1, "R5 hold with ce low");
        ce = 1'b1; step();
        check(lc_out, 0, "R5 load after ce returns");
        configure(16'hAAAA, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        ce = 1'b0; lc_in = 4'b0001; step();
        check(lc_out, 1, "R5 ce ignored when unused");
    endtask

    task automatic t_sr(input logic neg);
        configure(16'hAAAA, 1'b1, neg, 1'b1, 1'b1, 1'b0);   // reset mode
        ce = 1'b1; sr = 1'b0; lc_in = 4'b0001; step();
        check(lc_out, 1, "R6 preload");
        ce = 1'b0; sr = 1'b1; step();
        check(lc_out, 0, "R6 reset overrides ce low");
        ce = 1'b1; sr = 1'b1; lc_in = 4'b0001; step();
        check(lc_out, 0, "R6 reset beats lut one");
        configure(16'hAAAA, 1'b1, neg, 1'b1, 1'b1, 1'b1);   // set mode
        ce = 1'b0; sr = 1'b1; lc_in = 4'b0000; step();
        check(lc_out, 1, "R6 set overrides ce low");
        rst_n = 1'b0; step();
        check(lc_out, 0, "R9 reset beats set");
        rst_n = 1'b1; sr = 1'b0; ce = 1'b1;
    endtask

    task automatic t_sr_off();
        configure(16'hAAAA, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        sr = 1'b1; lc_in = 4'b0000; step();
        check(lc_out, 0, "R7 sr ignored (set mode)");
        cfg_sr_is_set = 1'b0; rst_n = 1'b0; step(); rst_n = 1'b1;
        lc_in = 4'b0001; step();
        check(lc_out, 1, "R7 sr ignored (reset mode)");
        sr = 1'b0;
    endtask

    task automatic t_carry();
        for (int v = 0; v < 8; v++) begin
            lc_in = {1'b0, v[1], v[0], 1'b0};
            carry_in = v[2];
            #1;
            check(carry_out, (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]), "R8 carry majority");
        end
        carry_in = 1'b0;
    endtask

    task automatic t_adder();
        int va [6] = '{0, 15, 7, 9, 15, 5};
        int vb [6] = '{0, 1, 8, 9, 15, 10};
        int vc [6] = '{0, 0, 1, 1, 1, 0};
        for (int i = 0; i < 6; i++) begin
            add_a = va[i][3:0]; add_b = vb[i][3:0]; add_cin = vc[i][0];
            #1;
            check({3'b0, add_c[W], add_s}, 8'(va[i] + vb[i] + vc[i]), "R10 ripple adder");
        end
    endtask

    task automatic t_counter();
        logic [W-1:0] exp_cnt = '0;
        cnt_rst_n = 1'b0;
        @(posedge clk); #1;
        cnt_rst_n = 1'b1;
        check({4'b0, cnt_q}, 0, "R10 counter reset");
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            exp_cnt = exp_cnt + 1'b1;
            check({4'b0, cnt_q}, {4'b0, exp_cnt}, "R10 counter step");
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset();
        t_lut();
        t_cascade();
        t_edges(1'b0);
        t_edges(1'b1);
        t_enable();
        t_sr(1'b0);
        t_sr(1'b1);
        t_sr_off();
        t_carry();
        t_adder();
        t_counter();
        report();
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(8 * 50000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end
endmodule